// File: doc/BRIEF.md
# Auto-Negotiation Next Page Transmit Register

This block holds the 16-bit next page word that an Ethernet PHY sends to its link partner after the base page during Auto-Negotiation. Station management software reaches it through a plain synchronous register port. A write whose address matches the register's address stores the flag and code fields. A read returns the assembled word. The same word is also driven straight to the negotiation logic on `np_word`.

The negotiation side uses three signals. `base_load` marks the moment the base page is committed, and `base_b11` carries bit 11 of that base page. `page_sent` is a one-cycle pulse for each next page that goes out on the wire. The block keeps the Toggle bit itself. It seeds the bit from the inverse of base page bit 11 and flips it on every page sent, so software never writes it.

A small sequencer with four states tracks the exchange. The states are:
- **EMPTY**: no fresh content since reset or since the base page was loaded.
- **ARMED**: management has written a page that has not yet been sent.
- **SENT**: a page went out with the more-pages flag set.
- **LAST**: a page went out with the more-pages flag clear.

The transitions are:
- **T_LOAD**: `base_load` moves any state to EMPTY, or to ARMED when a write lands in the same cycle.
- **T_WRITE**: a register write moves any state to ARMED.
- **T_SEND**: `page_sent` moves any state to SENT or to LAST, chosen by bit 15 of the word being sent.

When more than one event arrives in the same cycle, T_LOAD wins over T_WRITE, and T_WRITE wins over T_SEND. `np_pending` is high in ARMED. `last_page` is high in LAST.

Top module: `np_tx_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every field, the Toggle bit, `np_pending` and `last_page` become 0. `np_word` then reads 0x0000.
- R2: A write with `mgmt_addr == REG_ADDR` (default 7) stores the following fields, and `np_word` and the read data show them from the next cycle:
  - bit 15: more pages follow (1) or this is the last page (0);
  - bit 13: message page (1) or unformatted page (0);
  - bit 12: the local device can comply with the partner's message (1) or cannot (0);
  - bits 10:0: the message or unformatted code, copied unchanged.
- R3: Bit 14 is reserved. It always reads 0, and writing 1 to it changes nothing.
- R4: Bit 11 is the Toggle bit and is read-only. A management write never changes it.
- R5: Each `page_sent` pulse without `base_load` inverts the Toggle bit at that clock edge.
- R6: `base_load` sets the Toggle bit to the inverse of `base_b11`. This wins over a `page_sent` pulse in the same cycle.
- R7: A write to any other address stores nothing. A read from any other address returns 0x0000.
- R8: A matching write raises `np_pending`. A `page_sent` pulse or a `base_load` clears it, unless a matching write happens in the same cycle.
- R9: `last_page` rises after a `page_sent` while bit 15 is 0. It stays low after a send with bit 15 at 1. `base_load` or a new matching write clears it.
- R10: `np_pending` and `last_page` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mgmt_addr | input | ADDR_W (5) | Management register address |
| mgmt_we | input | 1 | Management write enable |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Read data for `mgmt_addr` (combinational) |
| base_load | input | 1 | Base page committed; reseeds Toggle |
| base_b11 | input | 1 | Bit 11 of the base page word |
| page_sent | input | 1 | One-cycle pulse per next page sent |
| np_word | output | 16 | Assembled next page word |
| np_pending | output | 1 | Written page not yet sent |
| last_page | output | 1 | Last sent page had bit 15 clear |

## Verification
Every effect of a write, a base load or a page-sent pulse comes from a register. It is therefore visible one clock edge after the cycle in which the stimulus was held. `mgmt_rdata` also reacts combinationally to the address held in that same cycle.

The driver holds each stimulus for one full cycle starting at a falling edge. It queues the value expected after the next rising edge. The monitor compares that value 1 ns after the rising edge, so each result is checked exactly one edge after its cause. That single edge is enough to see the priority of base load over a page sent, and of a write over a page sent.

// File: rtl/np_tx_pkg.sv
package np_tx_pkg;
    localparam int NP_WORD_W = 16;
    localparam int NP_CODE_W = 11;
    localparam int B_MORE    = 15;
    localparam int B_RSVD    = 14;
    localparam int B_MSG     = 13;
    localparam int B_ACK2    = 12;
    localparam int B_TOG     = 11;

    typedef enum logic [1:0] {
        NP_EMPTY = 2'd0,
        NP_ARMED = 2'd1,
        NP_SENT  = 2'd2,
        NP_LAST  = 2'd3
    } np_state_e;

    typedef struct packed {
        logic                 more;
        logic                 msg;
        logic                 ack2;
        logic [NP_CODE_W-1:0] code;
    } np_fields_t;
endpackage

// File: rtl/np_field_store.sv
module np_field_store
    import np_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [NP_WORD_W-1:0] wdata,
    output np_fields_t           fields
);
    logic unused_wbits;
    assign unused_wbits = wdata[B_RSVD] ^ wdata[B_TOG];

    always_ff @(posedge clk) begin
        if (rst) begin
            fields <= '0;
        end else if (wr_en) begin
            fields.more <= wdata[B_MORE];
            fields.msg  <= wdata[B_MSG];
            fields.ack2 <= wdata[B_ACK2];
            fields.code <= wdata[NP_CODE_W-1:0];
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> fields == $past(fields));
endmodule

// File: rtl/np_toggle_gen.sv
module np_toggle_gen (
    input  logic clk,
    input  logic rst,
    input  logic base_load,
    input  logic base_b11,
    input  logic page_sent,
    output logic toggle
);
    always_ff @(posedge clk) begin
        if (rst)            toggle <= 1'b0;
        else if (base_load) toggle <= ~base_b11;
        else if (page_sent) toggle <= ~toggle;
    end

    assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (page_sent && !base_load) |=> toggle != $past(toggle));
    assert_toggle_seed_R6: assert property (@(posedge clk) disable iff (rst)
        base_load |=> toggle == !$past(base_b11));
    assert_toggle_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!page_sent && !base_load) |=> $stable(toggle));
endmodule

// File: rtl/np_seq_fsm.sv
module np_seq_fsm
    import np_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic base_load,
    input  logic page_sent,
    input  logic more_flag,
    output logic pending,
    output logic last_page
);
    np_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= NP_EMPTY;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (base_load)      state_nx = wr_en ? NP_ARMED : NP_EMPTY;
        else if (wr_en)     state_nx = NP_ARMED;
        else if (page_sent) state_nx = more_flag ? NP_SENT : NP_LAST;
    end

    always_comb begin
        pending   = 1'b0;
        last_page = 1'b0;
        unique case (state)
            NP_EMPTY: ;
            NP_ARMED: pending   = 1'b1;
            NP_SENT:  ;
            NP_LAST:  last_page = 1'b1;
            default:  ;
        endcase
    end

    assert_pending_set_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pending);
    assert_pending_clr_R8: assert property (@(posedge clk) disable iff (rst)
        ((page_sent || base_load) && !wr_en) |=> !pending);
    assert_last_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (base_load || wr_en) |=> !last_page);
    assert_last_set_R9: assert property (@(posedge clk) disable iff (rst)
        (page_sent && !more_flag && !base_load && !wr_en) |=> last_page);
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pending, last_page}));
endmodule

// File: rtl/np_tx_reg.sv
module np_tx_reg
    import np_tx_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    mgmt_addr,
    input  logic                 mgmt_we,
    input  logic [NP_WORD_W-1:0] mgmt_wdata,
    output logic [NP_WORD_W-1:0] mgmt_rdata,
    input  logic                 base_load,
    input  logic                 base_b11,
    input  logic                 page_sent,
    output logic [NP_WORD_W-1:0] np_word,
    output logic                 np_pending,
    output logic                 last_page
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    logic       hit, wr_en, toggle;
    np_fields_t fields;

    assign hit   = (mgmt_addr == SEL);
    assign wr_en = mgmt_we && hit;

    np_field_store u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(mgmt_wdata), .fields(fields)
    );

    np_toggle_gen u_tog (
        .clk(clk), .rst(rst), .base_load(base_load), .base_b11(base_b11),
        .page_sent(page_sent), .toggle(toggle)
    );

    np_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .base_load(base_load),
        .page_sent(page_sent), .more_flag(fields.more),
        .pending(np_pending), .last_page(last_page)
    );

    assign np_word    = {fields.more, 1'b0, fields.msg, fields.ack2, toggle, fields.code};
    assign mgmt_rdata = hit ? np_word : '0;

    assert_tog_ro_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !base_load && !page_sent) |=> np_word[B_TOG] == $past(np_word[B_TOG]));
    assert_miss_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> (np_word[NP_CODE_W-1:0] == $past(np_word[NP_CODE_W-1:0])));
    always_comb assert_rsvd_zero_R3: assert (rst || mgmt_rdata[B_RSVD] == 1'b0);
endmodule

// File: tb/tb_np_tx_reg.sv
module tb_np_tx_reg;
    localparam int REG = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mgmt_addr = '0;
    logic        mgmt_we = 1'b0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic        base_load = 1'b0;
    logic        base_b11 = 1'b0;
    logic        page_sent = 1'b0;
    logic [15:0] np_word;
    logic        np_pending, last_page;

    always #2 clk = ~clk;

    np_tx_reg #(.ADDR_W(5), .REG_ADDR(REG)) dut (
        .clk(clk), .rst(rst), .mgmt_addr(mgmt_addr), .mgmt_we(mgmt_we),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .base_load(base_load),
        .base_b11(base_b11), .page_sent(page_sent), .np_word(np_word),
        .np_pending(np_pending), .last_page(last_page)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [33:0] q_exp[$];
    string       q_tag[$];

    logic        m_more, m_msg, m_ack, m_tog, m_pend, m_last;
    logic [10:0] m_code;

    task automatic step(input logic r, input logic [4:0] a, input logic we,
                        input logic [15:0] wd, input logic bl, input logic b11,
                        input logic ps, input string tag);
        logic wr;
        logic [15:0] w;
        @(negedge clk);
        rst = r; mgmt_addr = a; mgmt_we = we; mgmt_wdata = wd;
        base_load = bl; base_b11 = b11; page_sent = ps;
        wr = we && (a == 5'(REG));
        if (r) begin
            {m_more, m_msg, m_ack, m_tog, m_pend, m_last} = '0;
            m_code = '0;
        end else begin
            if (bl) begin
                m_last = 1'b0; m_pend = wr;
            end else if (wr) begin
                m_pend = 1'b1; m_last = 1'b0;
            end else if (ps) begin
                m_pend = 1'b0; m_last = !m_more;
            end
            if (bl)      m_tog = !b11;
            else if (ps) m_tog = !m_tog;
            if (wr) begin
                m_more = wd[15]; m_msg = wd[13]; m_ack = wd[12]; m_code = wd[10:0];
            end
        end
        w = {m_more, 1'b0, m_msg, m_ack, m_tog, m_code};
        q_exp.push_back({w, (a == 5'(REG)) ? w : 16'h0, m_pend, m_last});
        q_tag.push_back(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [33:0] e;
                logic [33:0] act;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                act = {np_word, mgmt_rdata, np_pending, last_page};
                checks++;
                if (act !== e) begin
                    failures++;
                    $display("FAIL %s: actual word=%h rd=%h pend=%b last=%b expected word=%h rd=%h pend=%b last=%b",
                             t, act[33:18], act[17:2], act[1], act[0],
                             e[33:18], e[17:2], e[1], e[0]);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(1, 5'(REG), 0, 16'h0, 0, 0, 0, "R1 reset");
        step(1, 5'(REG), 1, 16'hFFFF, 0, 0, 0, "R1 reset beats write");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 0, "R1 idle after reset");
        step(0, 5'(REG), 0, 16'h0, 1, 0, 0, "R6 seed from b11=0");
        step(0, 5'(REG), 1, 16'hB5A5, 0, 0, 0, "R2 R3 R4 write fields");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R5 R8 send clears pending");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R5 second flip R9 more set");
        step(0, 5'(REG), 1, 16'h4800, 0, 0, 0, "R3 R4 rsvd and toggle ignored");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R9 last page after send bit15=0");
        step(0, 5'(3), 1, 16'hFFFF, 0, 0, 0, "R7 other address ignored");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 0, "R7 readback unchanged");
        step(0, 5'(REG), 0, 16'h0, 1, 1, 1, "R6 load wins over send R9 clear");
        step(0, 5'(REG), 1, 16'h97FF, 0, 0, 1, "R8 write wins over send");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R9 send bit15=1 no last");
        step(0, 5'(REG), 1, 16'h2001, 1, 0, 0, "R8 write with load stays pending");
        step(0, 5'(REG), 0, 16'h0, 1, 1, 0, "R8 load clears pending");
        step(0, 5'(REG), 1, 16'h1234, 0, 0, 0, "R2 write code");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R9 send last page");
        step(0, 5'(REG), 1, 16'h8000, 0, 0, 0, "R9 write clears last");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R5 R10 send");
        for (int i = 0; i < 6; i++)
            step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R5 R10 repeated sends");
        step(0, 5'(REG), 1, 16'h0000, 0, 0, 0, "R2 write zero");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 1, "R9 last again");
        step(0, 5'(9), 0, 16'h0, 0, 0, 0, "R7 read other address zero");
        step(1, 5'(REG), 0, 16'h0, 0, 0, 0, "R1 reset mid run");
        step(0, 5'(REG), 0, 16'h0, 0, 0, 0, "R1 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule